// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial bus (I2C-compatible) placed in front of a small byte-wide on-chip memory. A fast system clock oversamples the clock line and the data line. Both lines pass through synchronizers and a glitch filter. The block then recognises bus conditions, shifts bytes in and out, and answers each byte it accepts with an acknowledge. It drives the data line through an open-drain style output: when `sda_low_o` is high, the line is pulled low; otherwise the line is left to the pull-up.

A write frame carries a device byte, a word address and zero or more data bytes. The data bytes collect in a page latch. They are copied into the array only when the frame ends with a Stop, and that copy starts a timed write cycle. While the write cycle runs, the block ignores the bus, so a host learns that the write has finished by repeating a device byte until it is acknowledged. A read frame returns bytes starting at an internal address pointer, which advances after every byte. A random read sets the pointer with a write frame that is cut short by a repeated Start.

Top module: `smem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a Start, and a rising data line while the clock is high is a Stop. Either condition releases the data line at once. A Start abandons any frame in progress, and page data latched before that Start is never written.
- R2: The first byte after a Start is the device byte. It is acknowledged when its bits 7:4 are 1010, whatever the values of bits 3:1. Bit 0 selects read (1) or write (0). Any other value in bits 7:4 gets no acknowledge, and the block then leaves the bus alone until the next Start.
- R3: In a write frame, the second byte loads the address pointer. Only its low log2(MEM_BYTES) bits are used, so with 128 bytes, bit 7 is ignored.
- R4: Every byte that is accepted is acknowledged by driving the line low for the whole ninth clock pulse. A single data byte that ends with a Stop is stored at the addressed location.
- R5: Each data byte in a write frame advances only the low log2(PAGE_BYTES) address bits, so the bytes wrap within the current page. Up to PAGE_BYTES bytes are stored by one frame.
- R6: A Stop that follows at least one accepted data byte starts a write cycle that lasts WR_CYCLES clocks. During that cycle, no byte is acknowledged (including the device byte) and the data line is never driven. A Stop that follows no data byte starts no write cycle.
- R7: A read returns bytes from consecutive addresses, and the address wraps from MEM_BYTES-1 to 0.
- R8: A read that does not set the address first begins one past the last byte that was read or written.
- R9: When the host does not acknowledge a read byte, the block releases the data line and stays off the bus until the next Start.
- R10: After a clock falling edge, the data output keeps its old value for at least HOLD_CYC system clocks before it changes.
- R11: A pulse on either line that lasts fewer than FILT_CYC system clocks (after synchronization) is ignored, so it creates no condition and no data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench polls right after each committed Stop and expects the first device byte to be refused. A design that kept acknowledging during the write cycle, or that started a cycle after a Stop with no data, fails this count. Page writes are started two bytes from the end of a page, and sequential reads run across address 127. These catch an address counter that carries into the page bits, or one that fails to wrap. A frame aborted by a repeated Start must leave the old contents in place, which catches a design that commits on any condition. Short dips on the data line during high clock phases would read as Start/Stop pairs without the filter. The bench also checks that each read bit is still on the line a little after the clock falls, which catches an output that changes directly on the detected edge.

// File: rtl/smem_pkg.sv
package smem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA
   } smem_state_e;

   localparam logic [3:0] DEV_PREFIX = 4'b1010;
   localparam int         BYTE_BITS  = 8;

endpackage

// File: rtl/smem_deglitch.sv
module smem_deglitch #(
   parameter int FILT_CYC    = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit RST_VAL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = $clog2(FILT_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          cnt_q;
   logic                   synced;

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{RST_VAL}};
         cnt_q  <= '0;
         dout   <= RST_VAL;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], din};
         if (synced == dout) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            dout  <= synced;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/smem_cond.sv
module smem_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/smem_wcycle.sv
module smem_wcycle #(
   parameter int WR_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);
   localparam int CW = $clog2(WR_CYCLES + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (kick)           left_q <= CW'(WR_CYCLES);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);
endmodule

// File: rtl/smem_slave.sv
module smem_slave
   import smem_pkg::*;
#(
   parameter int MEM_BYTES   = 128,
   parameter int PAGE_BYTES  = 8,
   parameter int FILT_CYC    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 15,
   parameter int WR_CYCLES   = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_low_o
);
   localparam int AW = $clog2(MEM_BYTES);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int HW = $clog2(HOLD_CYC + 1);

   // elaboration-time parameter checks
   if (MEM_BYTES < 2 || MEM_BYTES > 256 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two between 2 and 256");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES > MEM_BYTES || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two between 2 and MEM_BYTES");
   end
   if (FILT_CYC < 1 || HOLD_CYC < 1 || WR_CYCLES < 1) begin : g_bad_time
      $error("FILT_CYC, HOLD_CYC and WR_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // line conditioning: one filter per bus line
   logic [1:0] raw_w, flt_w;
   logic       scl_f, sda_f;
   assign raw_w = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      smem_deglitch #(
         .FILT_CYC   (FILT_CYC),
         .SYNC_STAGES(SYNC_STAGES),
         .RST_VAL    (1'b1)
      ) u_flt (
         .clk (clk),
         .rst_n(rst_n),
         .din (raw_w[g]),
         .dout(flt_w[g])
      );
   end
   assign scl_f = flt_w[1];
   assign sda_f = flt_w[0];

   logic scl_rise, scl_fall, start_det, stop_det;
   smem_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   logic commit, wc_busy;
   smem_wcycle #(.WR_CYCLES(WR_CYCLES)) u_wcyc (
      .clk  (clk),
      .rst_n(rst_n),
      .kick (commit),
      .busy (wc_busy)
   );

   // protocol state
   smem_state_e          state_q;
   logic [3:0]           bitcnt_q;
   logic [BYTE_BITS-1:0] shreg_q;
   logic [AW-1:0]        addr_q;
   logic                 rd_q, ack_q, mack_q;
   logic [PAGE_BYTES-1:0] pvalid_q;
   logic                 oe_q, pend_q, hact_q;
   logic [HW-1:0]        hcnt_q;

   logic [BYTE_BITS-1:0] mem_q  [MEM_BYTES];
   logic [BYTE_BITS-1:0] pbuf_q [PAGE_BYTES];

   logic                 rx_st, ctrl_ok, byte_ok, byte_end, pb_we;
   logic [PW-1:0]        pslot;
   logic [AW-PW-1:0]     ppage;
   logic [BYTE_BITS-1:0] rd_byte;

   assign rx_st    = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
   assign ctrl_ok  = (shreg_q[7:4] == DEV_PREFIX) && !wc_busy;
   assign byte_ok  = (state_q == ST_CTRL) ? ctrl_ok : !wc_busy;
   assign byte_end = rx_st && scl_fall && (bitcnt_q == 4'd8) && !start_det && !stop_det;
   assign pb_we    = byte_end && (state_q == ST_WDATA) && byte_ok;
   assign commit   = stop_det && (state_q == ST_WDATA) && (|pvalid_q);
   assign pslot    = addr_q[PW-1:0];
   assign ppage    = addr_q[AW-1:PW];
   assign rd_byte  = mem_q[addr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         addr_q   <= '0;
         rd_q     <= 1'b0;
         ack_q    <= 1'b0;
         mack_q   <= 1'b0;
         pvalid_q <= '0;
         oe_q     <= 1'b0;
         pend_q   <= 1'b0;
         hact_q   <= 1'b0;
         hcnt_q   <= '0;
      end else begin
         // delayed output update
         if (hact_q) begin
            if (hcnt_q == HW'(HOLD_CYC - 1)) begin
               oe_q   <= pend_q;
               hact_q <= 1'b0;
            end else begin
               hcnt_q <= hcnt_q + 1'b1;
            end
         end

         if (start_det) begin
            state_q  <= ST_CTRL;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            hact_q   <= 1'b0;
         end else if (stop_det) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            hact_q   <= 1'b0;
         end else if (rx_st) begin
            if (scl_rise && bitcnt_q < 4'd8) begin
               shreg_q  <= {shreg_q[6:0], sda_f};
               bitcnt_q <= bitcnt_q + 1'b1;
            end else if (byte_end) begin
               bitcnt_q <= 4'd9;
               ack_q    <= byte_ok;
               if (byte_ok) begin
                  pend_q <= 1'b1;
                  hact_q <= 1'b1;
                  hcnt_q <= '0;
               end
               case (state_q)
                  ST_CTRL:  rd_q <= shreg_q[0];
                  ST_ADDR:  if (byte_ok) begin
                               addr_q   <= shreg_q[AW-1:0];
                               pvalid_q <= '0;
                            end
                  ST_WDATA: if (byte_ok) begin
                               pvalid_q[pslot] <= 1'b1;
                               addr_q <= {ppage, PW'(pslot + 1'b1)};
                            end
                  default:  ;
               endcase
            end else if (scl_fall && bitcnt_q == 4'd9) begin
               bitcnt_q <= '0;
               pend_q   <= 1'b0;
               hact_q   <= 1'b1;
               hcnt_q   <= '0;
               if (!ack_q) begin
                  state_q <= ST_IDLE;
               end else if (state_q == ST_CTRL && rd_q) begin
                  state_q <= ST_RDATA;
                  shreg_q <= rd_byte;
                  addr_q  <= addr_q + 1'b1;
                  pend_q  <= !rd_byte[7];
               end else if (state_q == ST_CTRL) begin
                  state_q <= ST_ADDR;
               end else if (state_q == ST_ADDR) begin
                  state_q <= ST_WDATA;
               end
            end
         end else if (state_q == ST_RDATA) begin
            if (scl_rise) begin
               if (bitcnt_q < 4'd8) begin
                  bitcnt_q <= bitcnt_q + 1'b1;
               end else if (bitcnt_q == 4'd8) begin
                  mack_q   <= !sda_f;
                  bitcnt_q <= 4'd9;
               end
            end else if (scl_fall && bitcnt_q != 4'd0) begin
               hact_q <= 1'b1;
               hcnt_q <= '0;
               if (bitcnt_q < 4'd8) begin
                  shreg_q <= {shreg_q[6:0], 1'b0};
                  pend_q  <= !shreg_q[6];
               end else if (bitcnt_q == 4'd8) begin
                  pend_q <= 1'b0;
               end else begin
                  bitcnt_q <= '0;
                  if (mack_q) begin
                     shreg_q <= rd_byte;
                     addr_q  <= addr_q + 1'b1;
                     pend_q  <= !rd_byte[7];
                  end else begin
                     pend_q  <= 1'b0;
                     state_q <= ST_IDLE;
                  end
               end
            end
         end
      end
   end

   // page latch
   always_ff @(posedge clk) begin
      if (pb_we) pbuf_q[pslot] <= shreg_q;
   end

   // array update at the end of a write frame
   always_ff @(posedge clk) begin
      if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pvalid_q[i]) mem_q[{ppage, PW'(i)}] <= pbuf_q[i];
         end
      end
   end

   assign sda_low_o = oe_q;
endmodule

// File: rtl/smem_slave_chk.sv
module smem_slave_chk #(
   parameter int HOLD_CYC = 15
) (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic wc_busy,
   input logic start_det,
   input logic stop_det
);
   localparam int HW = $clog2(HOLD_CYC + 1);

   logic          scl_prev_q;
   logic [HW-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         since_q    <= HW'(HOLD_CYC);
      end else begin
         scl_prev_q <= scl_i;
         if (scl_prev_q && !scl_i)          since_q <= '0;
         else if (since_q != HW'(HOLD_CYC)) since_q <= since_q + 1'b1;
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_oe != $past(sda_oe)) && !scl_i) |-> (since_q >= HW'(HOLD_CYC))); // R10

   AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wc_busy |-> !sda_oe); // R6

   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe); // R1

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R1
endmodule

bind smem_slave smem_slave_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe   (sda_low_o),
   .wc_busy  (wc_busy),
   .start_det(start_det),
   .stop_det (stop_det)
);

// File: tb/smem_slave_bench.sv
module smem_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_low;
   logic sda_line;

   int n_cmp = 0;
   int n_bad = 0;
   bit hold_all = 1'b1;

   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_low;

   smem_slave u_smem_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_low_o(sda_low)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wait_cyc(30);
      scl_m = 1'b1; wait_cyc(20);
      sda_m = 1'b0; wait_cyc(20);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop;
      wait_cyc(10); sda_m = 1'b0; wait_cyc(30);
      scl_m = 1'b1; wait_cyc(20);
      sda_m = 1'b1; wait_cyc(40);
   endtask

   task automatic wr_bit(input logic b, input bit glitch);
      wait_cyc(10); sda_m = b; wait_cyc(30);
      scl_m = 1'b1; wait_cyc(5);
      if (glitch && b) begin
         sda_m = 1'b0; wait_cyc(1); sda_m = 1'b1;
      end
      wait_cyc(15);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) wr_bit(b[i], glitch);
      wait_cyc(10); sda_m = 1'b1; wait_cyc(30);
      scl_m = 1'b1; wait_cyc(10);
      ack = (sda_line == 1'b0);
      wait_cyc(10); scl_m = 1'b0;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         wait_cyc(10); sda_m = 1'b1; wait_cyc(30);
         scl_m = 1'b1; wait_cyc(10);
         d[i] = sda_line;
         wait_cyc(10); scl_m = 1'b0;
         wait_cyc(8);
         if (sda_line != d[i]) hold_all = 1'b0;
         wait_cyc(2);
      end
      sda_m = mack ? 1'b0 : 1'b1; wait_cyc(30);
      scl_m = 1'b1; wait_cyc(20);
      scl_m = 1'b0;
   endtask

   task automatic wr_xfer(input logic [7:0] a, input int n, input bit glitch, output bit acks);
      bit ak;
      bus_start;
      send_byte(8'hA0, 1'b0, ak); acks = ak;
      send_byte(a, 1'b0, ak);     acks &= ak;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], glitch, ak); acks &= ak;
      end
      bus_stop;
   endtask

   task automatic poll_ready(output int tries);
      bit ak;
      tries = 0;
      for (int k = 0; k < 50; k++) begin
         bus_start;
         send_byte(8'hA0, 1'b0, ak);
         bus_stop;
         tries++;
         if (ak) break;
      end
   endtask

   task automatic rd_at(input logic [7:0] a, input int n);
      bit ak;
      bus_start;
      send_byte(8'hA0, 1'b0, ak);
      send_byte(a, 1'b0, ak);
      bus_start;
      send_byte(8'hA1, 1'b0, ak);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      bus_stop;
   endtask

   task automatic rd_cur(input int n);
      bit ak;
      bus_start;
      send_byte(8'hA1, 1'b0, ak);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      bus_stop;
   endtask

   task automatic t_reset;
      wait_cyc(20);
      check("R1 reset line released", int'(sda_low), 0);
   endtask

   task automatic t_byte_write;
      bit acks; int tries;
      wbuf[0] = 8'h3C;
      wr_xfer(8'h85, 1, 1'b0, acks);
      check("R4 byte write acknowledged", int'(acks), 1);
      poll_ready(tries);
      check("R6 first poll refused during write cycle", int'(tries > 1), 1);
      rd_at(8'h05, 1);
      check("R3 address bit 7 ignored", int'(rbuf[0]), 'h3C);
   endtask

   task automatic t_ctrl;
      bit ak;
      bus_start;
      send_byte(8'hAE, 1'b0, ak);
      check("R2 device byte with bits 3:1 set acknowledged", int'(ak), 1);
      bus_stop;
      bus_start;
      send_byte(8'hB1, 1'b0, ak);
      check("R2 wrong prefix not acknowledged", int'(ak), 0);
      wait_cyc(30);
      check("R2 line released after refusal", int'(sda_low), 0);
      bus_stop;
   endtask

   task automatic t_page;
      bit acks; int tries;
      for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h10 + k * 7);
      wr_xfer(8'h10, 8, 1'b0, acks);
      check("R5 page write acknowledged", int'(acks), 1);
      poll_ready(tries);
      rd_at(8'h10, 8);
      for (int k = 0; k < 8; k++) check("R5 full page", int'(rbuf[k]), 8'h10 + k * 7);
      wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
      wr_xfer(8'h1E, 4, 1'b0, acks);
      poll_ready(tries);
      rd_at(8'h1E, 2);
      check("R5 page end byte 0", int'(rbuf[0]), 'hC1);
      check("R5 page end byte 1", int'(rbuf[1]), 'hC2);
      rd_at(8'h18, 2);
      check("R5 wrapped to page start", int'(rbuf[0]), 'hC3);
      check("R5 wrapped second byte", int'(rbuf[1]), 'hC4);
   endtask

   task automatic t_abort;
      bit acks, ak; int tries;
      wbuf[0] = 8'h77;
      wr_xfer(8'h30, 1, 1'b0, acks);
      poll_ready(tries);
      bus_start;
      send_byte(8'hA0, 1'b0, ak);
      send_byte(8'h30, 1'b0, ak);
      send_byte(8'h11, 1'b0, ak);
      bus_start;
      bus_stop;
      poll_ready(tries);
      check("R6 no write cycle after aborted frame", tries, 1);
      rd_at(8'h30, 1);
      check("R1 repeated start discards latched data", int'(rbuf[0]), 'h77);
   endtask

   task automatic t_wrap;
      bit acks; int tries;
      wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
      wr_xfer(8'h7E, 2, 1'b0, acks);
      poll_ready(tries);
      wbuf[0] = 8'hF0; wbuf[1] = 8'hF1;
      wr_xfer(8'h00, 2, 1'b0, acks);
      poll_ready(tries);
      rd_at(8'h7E, 4);
      check("R7 read at 7E", int'(rbuf[0]), 'hE1);
      check("R7 read at 7F", int'(rbuf[1]), 'hE2);
      check("R7 wrap to 00", int'(rbuf[2]), 'hF0);
      check("R7 read at 01", int'(rbuf[3]), 'hF1);
   endtask

   task automatic t_current;
      rd_at(8'h10, 3);
      rd_cur(1);
      check("R8 current address read", int'(rbuf[0]), 8'h10 + 3 * 7);
   endtask

   task automatic t_nack;
      bit ak;
      logic [7:0] d;
      bus_start;
      send_byte(8'hA0, 1'b0, ak);
      send_byte(8'h12, 1'b0, ak);
      bus_start;
      send_byte(8'hA1, 1'b0, ak);
      recv_byte(1'b0, d);
      check("R9 byte before not-acknowledge", int'(d), 8'h10 + 2 * 7);
      wait_cyc(10); sda_m = 1'b1; wait_cyc(30);
      scl_m = 1'b1; wait_cyc(10);
      check("R9 line high after not-acknowledge", int'(sda_line), 1);
      wait_cyc(10); scl_m = 1'b0;
      wait_cyc(30);
      check("R9 output released", int'(sda_low), 0);
      bus_stop;
   endtask

   task automatic t_glitch;
      bit acks; int tries;
      wbuf[0] = 8'hFF; wbuf[1] = 8'hA5;
      wr_xfer(8'h50, 2, 1'b1, acks);
      check("R11 glitched frame acknowledged", int'(acks), 1);
      poll_ready(tries);
      rd_at(8'h50, 2);
      check("R11 glitched byte 0", int'(rbuf[0]), 'hFF);
      check("R11 glitched byte 1", int'(rbuf[1]), 'hA5);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      t_reset;
      t_byte_write;
      t_ctrl;
      t_page;
      t_abort;
      t_wrap;
      t_current;
      t_nack;
      t_glitch;
      check("R10 read bits held after clock fall", int'(hold_all), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule